// File: doc/BRIEF.md
# UART Host Register and Interrupt Interface

This block sits between a host processor and the serial engines of a UART. The host reaches four byte-wide locations through a two-bit address with single-cycle write and read strobes. Behind them sit a transmit holding register, a receive holding register, a control register and a read-only status register. One interrupt line is driven from the status flags, gated by two enable bits in the control register.

Toward the transmitter the block offers the pending byte on a valid/ready stream. `tx_valid` stays high and `tx_data` stays constant until the cycle in which `tx_ready` is also high. Toward the receiver the stream has no back-pressure: a byte arrives with a one-cycle `rx_valid` strobe and is always consumed. If the holding register still holds an unread byte, the new byte is dropped and an overrun is recorded, so the receiver never stalls.

The block also divides the 8 MHz system clock into a 16x oversampling tick for the serial engines. The rate comes from a three-bit code in the control register.

Top module: `uart_host_regs`

## Requirements
- R1: After reset the status register reads 0x80, the control register reads 0x00, `irq` is 0, `tx_valid` is 0 and `baud_sel` is 0.
- R2: The address map is as follows. Address 0 writes the transmit byte and reads the receive byte. Address 1 is the control register, which reads back exactly as written, with bit 7 the receive interrupt enable, bit 6 the transmit interrupt enable and bits 2:0 the rate code. Address 2 is the status register: bit 7 transmit empty, bit 6 receive full, bit 5 overrun, bit 4 framing error, bits 3:0 zero. Address 3 reads 0. Writes to addresses 2 and 3 change nothing.
- R3: A write to address 0 puts the byte on `tx_data` with `tx_valid` high from the next cycle and clears transmit empty. The byte is held stable while `tx_ready` is low. The cycle after `tx_valid && tx_ready`, `tx_valid` is 0 and transmit empty is 1, unless a new write arrived in the same cycle. A write while a byte is pending replaces that byte.
- R4: When `rx_valid` arrives while receive full is 0, the byte is stored and receive full reads 1 from the next cycle. A read of address 0 clears receive full. A byte arriving in the same cycle as that read is stored with no overrun.
- R5: When `rx_valid` arrives while receive full is 1 and no read of address 0 happens in that cycle, overrun is set and the stored byte is kept.
- R6: An accepted byte that arrives with `rx_stop_err` high sets the framing error flag.
- R7: A read of address 2 followed later by a read of address 0 clears overrun and framing error. A read of address 0 with no status read since the previous read of address 0 leaves both flags set.
- R8: `irq` is high exactly when (receive enable and receive full) or (transmit enable and transmit empty).
- R9: `baud_sel` follows the control rate code. Codes 0 to 7 select 1200, 2400, 4800, 9600, 19200, 38400, 57600 and 115200 baud. `tick` is a single-cycle pulse every round(8,000,000 / (16 x rate)) cycles: 417, 208, 104, 52, 26, 13, 9 and 4.
- R10: A change of the rate code restarts the divider. The first tick at the new rate appears divisor+1 clock edges after the edge that wrote the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 8 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| rd_en | input | 1 | Single-cycle register read strobe (drives read side effects) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Shared interrupt request |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Transmitter takes the byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_stop_err | input | 1 | Received byte had a bad stop bit |
| baud_sel | output | 3 | Current rate code for the serial engines |
| tick | output | 1 | 16x oversampling enable pulse |

## Verification
Some rules are checked by the assertions on every cycle. These are the transmit stream holding its byte under back-pressure and dropping after a handshake, a receive strobe into a full register raising overrun without disturbing the stored byte, and a clearing read dropping both error flags. They also cover a new byte filling an empty register, each enabled source forcing the interrupt, and the tick being a single-cycle pulse that a rate change suppresses. Other behaviour only the bench scenarios can show: the exact divisor for each rate code, the two-step clearing order (including a data read that must not clear), a read and an arrival in the same cycle, a write that replaces a pending byte, and the register map seen through `rdata`.

// File: rtl/uhr_pkg.sv
package uhr_pkg;
  localparam int REG_W = 8;
  localparam int NUM_RATES = 8;

  typedef enum logic [1:0] {
    A_DATA  = 2'd0,
    A_CTRL  = 2'd1,
    A_STAT  = 2'd2,
    A_SPARE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic       rx_irq_en;
    logic       tx_irq_en;
    logic [2:0] spare;
    logic [2:0] rate;
  } ctrl_t;

  typedef struct packed {
    logic       tx_empty;
    logic       rx_full;
    logic       overrun;
    logic       frame_err;
    logic [3:0] zero;
  } stat_t;

  // Rates double from the base for codes 0..5, then two top rates.
  function automatic int unsigned baud_rate(int unsigned base, int unsigned code);
    if (code < 6) return base << code;
    else if (code == 6) return base * 48;
    else return base * 96;
  endfunction

  // Rounded clock cycles per oversampling tick.
  function automatic int unsigned tick_div(int unsigned clk_hz, int unsigned ovs,
                                           int unsigned rate);
    return (clk_hz + (rate * ovs) / 2) / (rate * ovs);
  endfunction
endpackage

// File: rtl/uhr_baud_tick.sv
module uhr_baud_tick
  import uhr_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 8_000_000,
  parameter int unsigned OVERSAMPLE = 16,
  parameter int unsigned BASE_BAUD  = 1200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  output logic       tick
);
  localparam int unsigned MAX_DIV = tick_div(CLK_HZ, OVERSAMPLE, BASE_BAUD);
  localparam int CNT_W = $clog2(MAX_DIV + 1);

  logic [CNT_W-1:0] reload_tab [NUM_RATES];
  logic [CNT_W-1:0] cnt;
  logic [2:0]       sel_prev;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_div
    localparam int unsigned DIV_G =
      tick_div(CLK_HZ, OVERSAMPLE, baud_rate(BASE_BAUD, g));
    assign reload_tab[g] = CNT_W'(DIV_G - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev <= 3'd0;
      cnt      <= reload_tab[0];
      tick     <= 1'b0;
    end else begin
      sel_prev <= sel;
      if (sel != sel_prev) begin
        cnt  <= reload_tab[sel];
        tick <= 1'b0;
      end else if (cnt == '0) begin
        cnt  <= reload_tab[sel];
        tick <= 1'b1;
      end else begin
        cnt  <= cnt - 1'b1;
        tick <= 1'b0;
      end
    end
  end

  // R9
  tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R10
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel) |=> !tick);
endmodule

// File: rtl/uhr_tx_hold.sv
module uhr_tx_hold
  import uhr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [REG_W-1:0] load_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [REG_W-1:0] tx_data,
  output logic             empty
);
  logic             pending;
  logic [REG_W-1:0] hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      hold    <= '0;
    end else if (load) begin
      pending <= 1'b1;
      hold    <= load_data;
    end else if (pending && tx_ready) begin
      pending <= 1'b0;
    end
  end

  assign tx_valid = pending;
  assign tx_data  = hold;
  assign empty    = !pending;

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !load |=> tx_valid && $stable(tx_data));

  // R3
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && !load |=> !tx_valid);
endmodule

// File: rtl/uhr_rx_hold.sv
module uhr_rx_hold
  import uhr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [REG_W-1:0] rx_data,
  input  logic             rx_stop_err,
  input  logic             rd_data,
  input  logic             rd_stat,
  output logic [REG_W-1:0] rdr,
  output logic             full,
  output logic             overrun,
  output logic             frame_err
);
  logic armed;
  logic take;
  logic lost;
  logic clr;

  assign take = rx_valid && (!full || rd_data);
  assign lost = rx_valid && full && !rd_data;
  assign clr  = rd_data && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdr       <= '0;
      full      <= 1'b0;
      overrun   <= 1'b0;
      frame_err <= 1'b0;
      armed     <= 1'b0;
    end else begin
      if (take) begin
        rdr  <= rx_data;
        full <= 1'b1;
      end else if (rd_data) begin
        full <= 1'b0;
      end

      if (lost)     overrun <= 1'b1;
      else if (clr) overrun <= 1'b0;

      if (take && rx_stop_err) frame_err <= 1'b1;
      else if (clr)            frame_err <= 1'b0;

      if (rd_data)      armed <= 1'b0;
      else if (rd_stat) armed <= 1'b1;
    end
  end

  // R4
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !full |=> full && (rdr == $past(rx_data)));

  // R5
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && full && !rd_data |=> overrun && $stable(rdr));

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && armed && !rx_valid |=> !overrun && !frame_err);
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uhr_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 8_000_000,
  parameter int unsigned OVERSAMPLE = 16,
  parameter int unsigned BASE_BAUD  = 1200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             irq,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [REG_W-1:0] tx_data,
  input  logic             rx_valid,
  input  logic [REG_W-1:0] rx_data,
  input  logic             rx_stop_err,
  output logic [2:0]       baud_sel,
  output logic             tick
);
  ctrl_t            ctrl_q;
  stat_t            stat;
  logic             tx_empty;
  logic [REG_W-1:0] rdr;
  logic             rx_full;
  logic             overrun;
  logic             frame_err;
  logic             wr_data;
  logic             rd_data;
  logic             rd_stat;

  assign wr_data = wr_en && (addr == A_DATA);
  assign rd_data = rd_en && (addr == A_DATA);
  assign rd_stat = rd_en && (addr == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ctrl_q <= '0;
    else if (wr_en && (addr == A_CTRL))  ctrl_q <= ctrl_t'(wdata);
  end

  uhr_tx_hold u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (wr_data),
    .load_data (wdata),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .empty     (tx_empty)
  );

  uhr_rx_hold u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .rx_data     (rx_data),
    .rx_stop_err (rx_stop_err),
    .rd_data     (rd_data),
    .rd_stat     (rd_stat),
    .rdr         (rdr),
    .full        (rx_full),
    .overrun     (overrun),
    .frame_err   (frame_err)
  );

  uhr_baud_tick #(
    .CLK_HZ     (CLK_HZ),
    .OVERSAMPLE (OVERSAMPLE),
    .BASE_BAUD  (BASE_BAUD)
  ) u_baud (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (ctrl_q.rate),
    .tick  (tick)
  );

  always_comb begin
    stat           = '0;
    stat.tx_empty  = tx_empty;
    stat.rx_full   = rx_full;
    stat.overrun   = overrun;
    stat.frame_err = frame_err;
  end

  always_comb begin
    case (addr)
      A_DATA:  rdata = rdr;
      A_CTRL:  rdata = ctrl_q;
      A_STAT:  rdata = stat;
      default: rdata = '0;
    endcase
  end

  assign irq      = (ctrl_q.rx_irq_en && rx_full) || (ctrl_q.tx_irq_en && tx_empty);
  assign baud_sel = ctrl_q.rate;

  // R8
  tie_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.tx_irq_en && !tx_valid |-> irq);

  // R8
  rie_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.rx_irq_en && rx_full |-> irq);
endmodule

// File: tb/uart_host_regs_test.sv
module uart_host_regs_test;
  localparam int PERIOD = 125;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq;
  logic       tx_valid;
  logic       tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'd0;
  logic       rx_stop_err = 1'b0;
  logic [2:0] baud_sel;
  logic       tick;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  uart_host_regs uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_stop_err(rx_stop_err), .baud_sel(baud_sel),
    .tick(tick)
  );

  // behavioural reference state
  int  m_tx_q[$];
  int  m_rx_byte, m_ctrl;
  bit  m_rx_full, m_ov, m_fe, m_armed;
  int  m_rate_prev, m_since;
  bit  m_tick;

  function automatic int div_for(int code);
    int rate;
    rate = (code < 6) ? (1200 * (1 << code)) : ((code == 6) ? 57600 : 115200);
    return $rtoi(8000000.0 / (16.0 * rate) + 0.5);
  endfunction

  function automatic int exp_rdata(int a);
    case (a)
      0: return m_rx_byte;
      1: return m_ctrl;
      2: return ((m_tx_q.size() == 0) << 7) | (m_rx_full << 6) | (m_ov << 5) | (m_fe << 4);
      default: return 0;
    endcase
  endfunction

  task automatic cmp(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tx_q.delete();
      m_rx_byte = 0; m_ctrl = 0; m_rx_full = 0; m_ov = 0; m_fe = 0; m_armed = 0;
      m_rate_prev = 0; m_since = 0; m_tick = 0;
    end else begin
      bit rdd, rds, clr, acc, ovr;
      // rate divider
      if ((m_ctrl & 7) != m_rate_prev) begin
        m_since = 0; m_tick = 0;
      end else begin
        m_since++;
        m_tick = (m_since % div_for(m_ctrl & 7)) == 0;
      end
      m_rate_prev = m_ctrl & 7;
      // transmit side: at most one pending byte
      if (m_tx_q.size() != 0 && tx_ready) void'(m_tx_q.pop_front());
      if (wr_en && addr == 2'd0) begin
        m_tx_q.delete();
        m_tx_q.push_back(wdata);
      end
      if (wr_en && addr == 2'd1) m_ctrl = wdata;
      // receive side
      rdd = rd_en && addr == 2'd0;
      rds = rd_en && addr == 2'd2;
      clr = rdd && m_armed;
      acc = rx_valid && (!m_rx_full || rdd);
      ovr = rx_valid && m_rx_full && !rdd;
      if (clr) begin m_ov = 0; m_fe = 0; end
      if (ovr) m_ov = 1;
      if (acc && rx_stop_err) m_fe = 1;
      if (acc) begin m_rx_byte = rx_data; m_rx_full = 1; end
      else if (rdd) m_rx_full = 0;
      if (rdd) m_armed = 0; else if (rds) m_armed = 1;
    end
    #(PERIOD/4);
    cmp("R3 tx_valid", tx_valid, m_tx_q.size() != 0);
    cmp("R3 tx_data", tx_data, (m_tx_q.size() != 0) ? m_tx_q[0] : tx_data);
    cmp("R2 rdata", rdata, exp_rdata(addr));
    cmp("R8 irq", irq, ((m_ctrl >> 7) & m_rx_full) | (((m_ctrl >> 6) & 1) & (m_tx_q.size() == 0)));
    cmp("R9 baud_sel", baud_sel, m_ctrl & 7);
    cmp("R10 tick", tick, m_tick);
  end

  task automatic drive(bit w, bit r, int a, int d, bit rv = 0, int rd = 0, bit err = 0);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = 2'(a); wdata = 8'(d);
    rx_valid = rv; rx_data = 8'(rd); rx_stop_err = err;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0);
  endtask

  task automatic peek(int a, int exp, string tag);
    drive(0, 0, a, 0);
    #1;
    cmp(tag, rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    peek(2, 8'h80, "R1 status");
    cmp("R1 irq", irq, 0);
    cmp("R1 tx_valid", tx_valid, 0);
    peek(1, 8'h00, "R1 ctrl");
    idle(430);                          // R9 one tick period at code 0
    drive(1, 0, 1, 8'h47);              // tx enable, spare bits, code 7
    peek(1, 8'h47, "R2 ctrl readback");
    cmp("R8 tx irq", irq, 1);
    idle(20);                           // R10 new period after change
    drive(1, 0, 0, 8'hA5);
    peek(2, 8'h00, "R3 tdre clear");
    cmp("R8 irq low", irq, 0);
    idle(3);
    drive(1, 0, 0, 8'h3C);              // R3 replace pending byte
    idle(2);
    cmp("R3 replaced", tx_data, 8'h3C);
    tx_ready = 1'b1;
    idle(2);
    peek(2, 8'h80, "R3 tdre set");
    drive(1, 0, 2, 8'hFF);              // R2 write to status ignored
    drive(1, 0, 3, 8'hFF);
    peek(2, 8'h80, "R2 status unchanged");
    peek(3, 8'h00, "R2 spare reads zero");
    drive(1, 0, 1, 8'h86);              // rx enable, code 6
    drive(0, 0, 0, 0, 1, 8'h11);
    peek(2, 8'hC0, "R4 rdrf set");
    cmp("R8 rx irq", irq, 1);
    peek(0, 8'h11, "R4 rdr byte");
    drive(0, 1, 0, 0);
    peek(2, 8'h80, "R4 rdrf clear");
    drive(0, 0, 0, 0, 1, 8'h22);
    drive(0, 0, 0, 0, 1, 8'h33);
    peek(0, 8'h22, "R5 old byte kept");
    peek(2, 8'hE0, "R5 overrun set");
    drive(0, 1, 0, 0);                  // data read without status read
    peek(2, 8'hA0, "R7 no clear without status read");
    drive(0, 1, 2, 0);
    drive(0, 1, 0, 0);
    peek(2, 8'h80, "R7 cleared");
    drive(0, 0, 0, 0, 1, 8'h44, 1);
    peek(2, 8'hD0, "R6 frame error");
    drive(0, 1, 2, 0);
    idle(2);
    drive(0, 1, 0, 0);
    peek(2, 8'h80, "R7 fe cleared");
    drive(0, 0, 0, 0, 1, 8'h55);
    drive(0, 1, 0, 0, 1, 8'h66);        // R4 read and arrival same cycle
    peek(2, 8'hC0, "R4 same-cycle no overrun");
    peek(0, 8'h66, "R4 same-cycle byte");
    drive(1, 0, 1, 8'h03);              // code 3
    idle(130);
    for (int i = 0; i < 24; i++) begin
      tx_ready = i[1];
      drive(i[0], 0, 0, i * 7);
    end
    tx_ready = 1'b1;
    drive(1, 0, 1, 8'hC7);
    idle(40);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule